// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast clock, typically a VCO output inside a PLL, by a programmable modulus. The modulus is set by a swallow count A and a main count M. A prescaler divides the input clock by either N or N+1. Within one division cycle, the main counter counts M prescaler periods. The first A of those periods use the longer ratio N+1 and the rest use N. The whole cycle therefore lasts N·M + A input clocks. At the end of each cycle the block emits a single-clock pulse, which goes to a phase-frequency detector outside this block.

The A and M values are copied into working registers only while reset is held and at the last clock of a division cycle. A change made part way through a cycle therefore never shortens or stretches the cycle in progress. A setting with A greater than M cannot be produced by this structure. A setting with M equal to zero has no meaning. Either one raises an error flag, and the output pulse is withheld for as long as that setting is in use. Because A must not exceed M, some totals below 8·7 cannot be reached with N = 8.

Top module: `fbdiv_top`

## Requirements
- R1: While a legal setting is held, consecutive rising edges of `fb_pulse_o` are exactly N·M + A input clocks apart (N = 8 by default).
- R2: After reset is released, the first pulse is high after the (N·M + A)-th rising clock edge.
- R3: `fb_pulse_o` is high for exactly one clock period.
- R4: Within a cycle, the prescaler divides by N+1 for the first A prescaler periods and by N for the remaining M − A. With A = M, every period is N+1 long, so A = M = 7 gives 63.
- R5: A setting with A > M is illegal. It sets `cfg_err_o` = 1, and no pulse is produced while it is in use.
- R6: A setting with M = 0 is illegal. It sets `cfg_err_o` = 1, and no pulse is produced while it is in use.
- R7: `swallow_i` and `main_i` are sampled only during reset and on the last clock of a division cycle. A change made mid-cycle takes effect from the following cycle.
- R8: `cfg_err_o` is updated at the same clock as the setting it describes is loaded. After an illegal setting is replaced by a legal one, the first pulse comes N·M + A clocks after `cfg_err_o` falls.
- R9: While reset is high, `fb_pulse_o` is 0 and `cfg_err_o` reflects the setting on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads the setting |
| swallow_i | input | A_W (3) | Swallow count A |
| main_i | input | M_W (8) | Main count M |
| fb_pulse_o | output | 1 | One-clock pulse per completed division cycle |
| cfg_err_o | output | 1 | Setting in use is illegal (A > M or M = 0) |

## Verification
The modulus is measured for several A and M pairs, each chosen to separate a different fault:
- A = 0 isolates the pure divide-by-N path.
- A = M = 7 forces every period onto the N+1 ratio.
- Mixed pairs such as 3/5 and 5/20 show whether the switch-over point is placed correctly.
- M = 255 exercises the full width of the main counter.

Illegal pairs, one with A > M and one with M = 0, must keep the output silent. A mid-cycle change of setting shows that loading happens only at the cycle boundary. A change from an illegal setting to a legal one times the first pulse from the moment the error flag drops.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int PRE_N_DEF = 8;
  localparam int M_W_DEF   = 8;

  typedef enum logic {
    DIV_BY_N  = 1'b0,
    DIV_BY_N1 = 1'b1
  } psc_mode_e;
endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg #(
  parameter int A_W = 3,
  parameter int M_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [M_W-1:0] m_in,
  output logic [A_W-1:0] act_a,
  output logic [M_W-1:0] act_m,
  output logic           act_bad
);
  logic bad_in;

  // illegal: swallow count above main count, or empty main count
  always_comb begin
    bad_in = (M_W'(a_in) > m_in) || (m_in == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      act_a   <= a_in;
      act_m   <= m_in;
      act_bad <= bad_in;
    end
  end
endmodule

// File: rtl/fbdiv_presc.sv
module fbdiv_presc
  import fbdiv_pkg::*;
#(
  parameter int PRE_N = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  psc_mode_e mode,
  output logic      tc
);
  localparam int PW = $clog2(PRE_N + 1);

  logic [PW-1:0] pc;
  logic [PW-1:0] last;

  always_comb begin
    last = (mode == DIV_BY_N1) ? PW'(PRE_N) : PW'(PRE_N - 1);
    tc   = (pc == last);
  end

  always_ff @(posedge clk) begin
    if (rst || tc) pc <= '0;
    else           pc <= pc + PW'(1);
  end
endmodule

// File: rtl/fbdiv_ctr.sv
module fbdiv_ctr
  import fbdiv_pkg::*;
#(
  parameter int A_W = 3,
  parameter int M_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tc,
  input  logic [A_W-1:0] act_a,
  input  logic [M_W-1:0] act_m,
  output psc_mode_e      mode,
  output logic           cyc_end
);
  localparam int CW = M_W + 1;

  logic [M_W-1:0] mc;
  logic [CW-1:0]  mc_nxt;
  logic           mc_last;

  always_comb begin
    mc_nxt  = {1'b0, mc} + CW'(1);
    mc_last = (mc_nxt >= {1'b0, act_m});
    mode    = (M_W'(act_a) > mc) ? DIV_BY_N1 : DIV_BY_N;
    cyc_end = tc && mc_last;
  end

  always_ff @(posedge clk) begin
    if (rst || cyc_end) mc <= '0;
    else if (tc)        mc <= mc_nxt[M_W-1:0];
  end
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int PRE_N = fbdiv_pkg::PRE_N_DEF,
  parameter int M_W   = fbdiv_pkg::M_W_DEF,
  parameter int A_W   = $clog2(PRE_N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] swallow_i,
  input  logic [M_W-1:0] main_i,
  output logic           fb_pulse_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] act_a_w;
  logic [M_W-1:0] act_m_w;
  logic           act_bad_w;
  psc_mode_e      mode_w;
  logic           pre_tc_w;
  logic           cyc_end_w;

  fbdiv_cfg #(.A_W(A_W), .M_W(M_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (cyc_end_w),
    .a_in    (swallow_i),
    .m_in    (main_i),
    .act_a   (act_a_w),
    .act_m   (act_m_w),
    .act_bad (act_bad_w)
  );

  fbdiv_presc #(.PRE_N(PRE_N)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .mode (mode_w),
    .tc   (pre_tc_w)
  );

  fbdiv_ctr #(.A_W(A_W), .M_W(M_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .tc      (pre_tc_w),
    .act_a   (act_a_w),
    .act_m   (act_m_w),
    .mode    (mode_w),
    .cyc_end (cyc_end_w)
  );

  always_ff @(posedge clk) begin
    if (rst) fb_pulse_o <= 1'b0;
    else     fb_pulse_o <= cyc_end_w && !act_bad_w;
  end

  assign cfg_err_o = act_bad_w;
endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk
  import fbdiv_pkg::*;
#(
  parameter int A_W = 3,
  parameter int M_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           fb_pulse_o,
  input logic           cfg_err_o,
  input psc_mode_e      mode,
  input logic           pre_tc,
  input logic           cyc_end,
  input logic [A_W-1:0] act_a,
  input logic [M_W-1:0] act_m
);
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    fb_pulse_o |=> !fb_pulse_o); // R3

  AST_PULSE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    fb_pulse_o |-> $past(cyc_end)); // R1

  AST_END_ON_TC: assert property (@(posedge clk) disable iff (rst)
    cyc_end |-> pre_tc); // R1

  AST_NO_PULSE_BAD: assert property (@(posedge clk) disable iff (rst)
    fb_pulse_o |-> !$past(cfg_err_o)); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> ($stable(act_a) && $stable(act_m))); // R7

  AST_MODE_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == DIV_BY_N1 && mode == DIV_BY_N) |-> $past(pre_tc)); // R4
endmodule

bind fbdiv_top fbdiv_chk #(.A_W(A_W), .M_W(M_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fb_pulse_o (fb_pulse_o),
  .cfg_err_o  (cfg_err_o),
  .mode       (mode_w),
  .pre_tc     (pre_tc_w),
  .cyc_end    (cyc_end_w),
  .act_a      (act_a_w),
  .act_m      (act_m_w)
);

// File: tb/sim_fbdiv_top.sv
module sim_fbdiv_top;
  localparam int PRE_N = 8;
  localparam int M_W   = 8;
  localparam int A_W   = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [A_W-1:0] swallow_i = '0;
  logic [M_W-1:0] main_i = 8'd1;
  logic           fb_pulse_o;
  logic           cfg_err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fbdiv_top #(.PRE_N(PRE_N), .M_W(M_W), .A_W(A_W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .swallow_i  (swallow_i),
    .main_i     (main_i),
    .fb_pulse_o (fb_pulse_o),
    .cfg_err_o  (cfg_err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int a, input int m);
    @(negedge clk);
    rst = 1'b1;
    swallow_i = A_W'(a);
    main_i = M_W'(m);
    repeat (3) @(negedge clk);
    chk(fb_pulse_o == 1'b0, "R9 pulse low in reset", int'(fb_pulse_o), 0);
    chk(cfg_err_o == ((a > m) || (m == 0)), "R9 err in reset", int'(cfg_err_o),
        int'((a > m) || (m == 0)));
    rst = 1'b0;
  endtask

  // n counts negedges; returns when a pulse is seen, or n = limit+1
  task automatic wait_pulse(input int limit, inout int n);
    while (n <= limit) begin
      @(negedge clk);
      n++;
      if (fb_pulse_o) return;
    end
  endtask

  task automatic t_modulus(input int a, input int m, input string tag);
    int t = PRE_N * m + a;
    int n = 0;
    do_reset(a, m);
    chk(cfg_err_o == 1'b0, {tag, " legal err"}, int'(cfg_err_o), 0);
    wait_pulse(t + 5, n);
    chk(n == t, {"R2 first pulse ", tag}, n, t);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      @(negedge clk);
      n++;
      chk(fb_pulse_o == 1'b0, {"R3 width ", tag}, int'(fb_pulse_o), 0);
      wait_pulse(t + 5, n);
      chk(n == t, {"R1 interval ", tag}, n, t);
    end
  endtask

  task automatic t_illegal(input int a, input int m, input string tag);
    int seen = 0;
    do_reset(a, m);
    chk(cfg_err_o == 1'b1, {tag, " err flag"}, int'(cfg_err_o), 1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (fb_pulse_o) seen++;
    end
    chk(seen == 0, {tag, " pulses suppressed"}, seen, 0);
    chk(cfg_err_o == 1'b1, {tag, " err held"}, int'(cfg_err_o), 1);
  endtask

  task automatic t_midcycle;
    int n = 0;
    do_reset(2, 4);
    wait_pulse(40, n);
    chk(n == 34, "R7 first 2/4", n, 34);
    repeat (5) @(negedge clk);
    swallow_i = 3'd1;
    main_i = 8'd6;
    n = 5;
    wait_pulse(40, n);
    chk(n == 34, "R7 old setting kept mid-cycle", n, 34);
    n = 0;
    wait_pulse(60, n);
    chk(n == 49, "R7 new setting next cycle", n, 49);
  endtask

  task automatic t_recover;
    int n = 0;
    do_reset(5, 3);
    repeat (5) @(negedge clk);
    swallow_i = 3'd1;
    main_i = 8'd2;
    while (cfg_err_o && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(cfg_err_o == 1'b0, "R8 err clears at boundary", int'(cfg_err_o), 0);
    chk(n == 22, "R8 err clears after 27-clock illegal cycle", n, 22);
    n = 0;
    wait_pulse(30, n);
    chk(n == 17, "R8 first pulse after recovery", n, 17);
    n = 0;
    wait_pulse(30, n);
    chk(n == 17, "R1 interval after recovery", n, 17);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_modulus(0, 1, "A0M1");
    t_modulus(3, 5, "A3M5");
    t_modulus(7, 7, "R4 A7M7");
    t_modulus(0, 10, "A0M10");
    t_modulus(5, 20, "R4 A5M20");
    t_modulus(6, 6, "R4 A6M6");
    t_modulus(7, 255, "A7M255");
    t_illegal(5, 3, "R5 A5M3");
    t_illegal(0, 0, "R6 A0M0");
    t_midcycle();
    t_recover();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule